// File: doc/BRIEF.md
# Slow-Domain Real-Time Clock with Handshaked Register Writes

This peripheral keeps wall-clock time in a counter clocked by a 32 kHz low-power clock. The counter is 47 bits wide: 32 bits of whole seconds sit above a 15-bit sub-second fraction. Next to the counter sit a seconds/fraction alarm, a control register that holds the counter enable, a status register and an interrupt-enable register. The registers are reached through a single-cycle 32-bit read/write port in the bus clock domain. One interrupt line is the OR of the enabled status flags.

Every register that lives in the slow domain is written through a toggle request/acknowledge handshake. A write raises a busy flag. When the slow side has applied the write and the acknowledge has come back, a write-complete flag is set. Any read of status clears write-complete. Interrupt-enable is the one register that is written at bus speed, and it never touches the handshake flags. A second slow-domain write issued while the first is still in flight is refused and flagged as an error.

Software brings the clock up in a fixed order. It clears the power-up invalid flags, loads the seconds, and sets the enable. The counter stays frozen until all three have happened.

Top module: `lp_rtc`

## Requirements
- R1: After reset, status reads 0x203: non-valid (bit 1), violation (bit 0) and write-next (bit 9) set, all else clear. Counter seconds and control read 0, alarm seconds read 0xFFFFFFFF, and irq_o is low.
- R2: A write to offset 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 sets write-busy (status bit 10) and clears write-next (bit 9) until the slow-domain acknowledge returns. Write-complete (bit 8) is set in the same cycle that busy drops.
- R3: Any read of status (offset 0x14) clears write-complete. If completion and the read fall in the same cycle, the set wins.
- R4: Interrupt-enable (offset 0x18) takes effect at bus speed. Only bits 9, 8, 7 and 4 are stored and read back. Writing it never sets busy or write-complete.
- R5: A slow-domain write issued while busy is refused. It sets write-error (status bit 7) and leaves the target register unchanged.
- R6: Writing 1 to status bits 7, 4, 1 or 0 clears that flag, and writing 0 leaves it. The clear is itself a handshaked write.
- R7: The counter advances by one per slow-clock edge only when all three hold: control bit 3 is set, seconds (offset 0x00) has been written since reset, and non-valid is clear. The fraction (offset 0x04, 15 bits) carries into the seconds.
- R8: The alarm flag (status bit 4) is set on the slow edge at which the counter steps onto {alarm seconds 0x08, alarm fraction 0x0C}. Alarm seconds reset to all ones, which keeps the alarm effectively unset.
- R9: irq_o is high whenever any of status bits 9, 8, 7 or 4 is set together with the same bit in interrupt-enable.
- R10: A read returns the addressed register on rdata_o in the cycle after rd_en_i. Fraction fields read as 15 bits, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| lp_clk_i | input | 1 | 32 kHz slow clock that drives the counter |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- wr_en_i and rd_en_i are never high in the same cycle.
- Reset is released with both clocks running.
- Multi-bit counter fields are only compared while the counter is stopped, or across a window whose length is known.

The stimulus follows these rules as well. It drives the port on the falling bus edge and issues one access per cycle. It reads the counter only after a handshaked write has turned the enable off. Any check that depends on elapsed slow-clock time is given a band of a few slow cycles, so the phase uncertainty of the two synchronizers stays inside it.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CSEC  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFRAC = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_ASEC  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_AFRAC = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 5'h18;

  localparam int ST_BUSY = 10;
  localparam int ST_NEXT = 9;
  localparam int ST_DONE = 8;
  localparam int ST_ERR  = 7;
  localparam int ST_ALM  = 4;
  localparam int ST_NV   = 1;
  localparam int ST_SV   = 0;
  localparam int CTRL_EN = 3;

  localparam logic [DATA_W-1:0] IEN_MASK = 32'h0000_0390;
endpackage

// File: rtl/lp_rtc_xfer.sv
module lp_rtc_xfer
  import lp_rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] hold_addr_o,
  output logic [DATA_W-1:0] hold_data_o,
  input  logic              lp_clk_i,
  output logic              lp_stb_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic                   req_q, busy_q, ack_seen_q;
  logic [ADDR_W-1:0]      hold_addr_q;
  logic [DATA_W-1:0]      hold_data_q;
  logic [SYNC_STAGES-1:0] ack_sync_q, req_sync_q;
  logic                   req_seen_q;
  logic                   done_w;

  assign done_w = ack_sync_q[LAST] ^ ack_seen_q;

  // bus side: launch toggles request, returning ack edge ends busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q       <= 1'b0;
      busy_q      <= 1'b0;
      hold_addr_q <= '0;
      hold_data_q <= '0;
      ack_sync_q  <= '0;
      ack_seen_q  <= 1'b0;
    end else begin
      ack_sync_q <= {ack_sync_q[SYNC_STAGES-2:0], req_seen_q};
      ack_seen_q <= ack_sync_q[LAST];
      if (launch_i) begin
        req_q       <= ~req_q;
        busy_q      <= 1'b1;
        hold_addr_q <= addr_i;
        hold_data_q <= data_i;
      end else if (done_w) begin
        busy_q <= 1'b0;
      end
    end
  end

  // slow side: the seen copy doubles as the acknowledge toggle
  always_ff @(posedge lp_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sync_q <= '0;
      req_seen_q <= 1'b0;
    end else begin
      req_sync_q <= {req_sync_q[SYNC_STAGES-2:0], req_q};
      req_seen_q <= req_sync_q[LAST];
    end
  end

  assign lp_stb_o    = req_sync_q[LAST] ^ req_seen_q;
  assign busy_o      = busy_q;
  assign done_o      = done_w;
  assign hold_addr_o = hold_addr_q;
  assign hold_data_o = hold_data_q;

  AST_BUSY_TILL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_w) |=> busy_q);  // R2
  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w |-> busy_q);  // R2
  AST_LAUNCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q);  // R5
  AST_STB_PULSE: assert property (@(posedge lp_clk_i) disable iff (!rst_ni)
    lp_stb_o |=> !lp_stb_o);  // R2
endmodule

// File: rtl/lp_rtc_core.sv
module lp_rtc_core
  import lp_rtc_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              lp_clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SEC_W-1:0]  cnt_sec_o,
  output logic [FRAC_W-1:0] cnt_frac_o,
  output logic [SEC_W-1:0]  alm_sec_o,
  output logic [FRAC_W-1:0] alm_frac_o,
  output logic              run_en_o,
  output logic              flag_alm_o,
  output logic              flag_nv_o,
  output logic              flag_sv_o
);
  localparam int CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] cnt_q, alm_q, cnt_nxt;
  logic             en_q, sec_wr_q, alm_f_q, nv_q, sv_q;
  logic             wr_csec, wr_cfrac, wr_asec, wr_afrac, wr_ctrl, wr_stat, wr_cnt;
  logic             run_w;

  assign wr_csec  = stb_i && (addr_i == OFS_CSEC);
  assign wr_cfrac = stb_i && (addr_i == OFS_CFRAC);
  assign wr_asec  = stb_i && (addr_i == OFS_ASEC);
  assign wr_afrac = stb_i && (addr_i == OFS_AFRAC);
  assign wr_ctrl  = stb_i && (addr_i == OFS_CTRL);
  assign wr_stat  = stb_i && (addr_i == OFS_STAT);
  assign wr_cnt   = wr_csec || wr_cfrac;

  assign run_w   = en_q && sec_wr_q && !nv_q;
  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge lp_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sec_wr_q <= 1'b0;
    end else if (wr_csec) begin
      cnt_q[CNT_W-1:FRAC_W] <= data_i[SEC_W-1:0];
      sec_wr_q              <= 1'b1;
    end else if (wr_cfrac) begin
      cnt_q[FRAC_W-1:0] <= data_i[FRAC_W-1:0];
    end else if (run_w) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge lp_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= {{SEC_W{1'b1}}, {FRAC_W{1'b0}}};
      en_q  <= 1'b0;
    end else begin
      if (wr_asec)  alm_q[CNT_W-1:FRAC_W] <= data_i[SEC_W-1:0];
      if (wr_afrac) alm_q[FRAC_W-1:0]     <= data_i[FRAC_W-1:0];
      if (wr_ctrl)  en_q                  <= data_i[CTRL_EN];
    end
  end

  // sticky flags; the alarm is raised by the step onto the match, set wins
  always_ff @(posedge lp_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_f_q <= 1'b0;
      nv_q    <= 1'b1;
      sv_q    <= 1'b1;
    end else begin
      if (run_w && !wr_cnt && (cnt_nxt == alm_q)) alm_f_q <= 1'b1;
      else if (wr_stat && data_i[ST_ALM])         alm_f_q <= 1'b0;
      if (wr_stat && data_i[ST_NV]) nv_q <= 1'b0;
      if (wr_stat && data_i[ST_SV]) sv_q <= 1'b0;
    end
  end

  assign cnt_sec_o  = cnt_q[CNT_W-1:FRAC_W];
  assign cnt_frac_o = cnt_q[FRAC_W-1:0];
  assign alm_sec_o  = alm_q[CNT_W-1:FRAC_W];
  assign alm_frac_o = alm_q[FRAC_W-1:0];
  assign run_en_o   = en_q;
  assign flag_alm_o = alm_f_q;
  assign flag_nv_o  = nv_q;
  assign flag_sv_o  = sv_q;

  AST_CNT_FROZEN: assert property (@(posedge lp_clk_i) disable iff (!rst_ni)
    (!run_w && !stb_i) |=> $stable(cnt_q));  // R7
  AST_CNT_STEP: assert property (@(posedge lp_clk_i) disable iff (!rst_ni)
    (run_w && !wr_cnt) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));  // R7
  AST_ALM_STICKY: assert property (@(posedge lp_clk_i) disable iff (!rst_ni)
    (alm_f_q && !wr_stat) |=> alm_f_q);  // R8
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
  import lp_rtc_pkg::*;
#(
  parameter int SEC_W       = 32,
  parameter int FRAC_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lp_clk_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int NFLAG = 3;
  localparam logic [NFLAG-1:0] FLAG_RST = 3'b011;  // {alarm, non-valid, violation}

  logic              is_ien, is_lp, wr_lp, launch, reject;
  logic              busy, done, lp_stb;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic [SEC_W-1:0]  cnt_sec, alm_sec;
  logic [FRAC_W-1:0] cnt_frac, alm_frac;
  logic              run_en, f_alm, f_nv, f_sv;
  logic              wcf_q, wef_q;
  logic [DATA_W-1:0] ien_q, rdata_q, stat_w, rd_w;
  logic [SYNC_STAGES-1:0][NFLAG-1:0] fsync_q;
  logic [NFLAG-1:0]  flags_b;

  always_comb begin
    unique case (addr_i)
      OFS_CSEC, OFS_CFRAC, OFS_ASEC, OFS_AFRAC, OFS_CTRL, OFS_STAT: is_lp = 1'b1;
      default: is_lp = 1'b0;
    endcase
  end

  assign is_ien = (addr_i == OFS_IEN);
  assign wr_lp  = wr_en_i && is_lp;
  assign launch = wr_lp && !busy;
  assign reject = wr_lp && busy;

  lp_rtc_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .addr_i      (addr_i),
    .data_i      (wdata_i),
    .busy_o      (busy),
    .done_o      (done),
    .hold_addr_o (hold_addr),
    .hold_data_o (hold_data),
    .lp_clk_i    (lp_clk_i),
    .lp_stb_o    (lp_stb)
  );

  lp_rtc_core #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_core (
    .lp_clk_i   (lp_clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (lp_stb),
    .addr_i     (hold_addr),
    .data_i     (hold_data),
    .cnt_sec_o  (cnt_sec),
    .cnt_frac_o (cnt_frac),
    .alm_sec_o  (alm_sec),
    .alm_frac_o (alm_frac),
    .run_en_o   (run_en),
    .flag_alm_o (f_alm),
    .flag_nv_o  (f_nv),
    .flag_sv_o  (f_sv)
  );

  // slow-domain flags into the bus domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fsync_q <= {SYNC_STAGES{FLAG_RST}};
    else         fsync_q <= {fsync_q[SYNC_STAGES-2:0], {f_alm, f_nv, f_sv}};
  end
  assign flags_b = fsync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcf_q <= 1'b0;
      wef_q <= 1'b0;
      ien_q <= '0;
    end else begin
      if (done)                                   wcf_q <= 1'b1;
      else if (rd_en_i && (addr_i == OFS_STAT))   wcf_q <= 1'b0;
      if (reject)                                 wef_q <= 1'b1;
      else if (done && (hold_addr == OFS_STAT) && hold_data[ST_ERR]) wef_q <= 1'b0;
      if (wr_en_i && is_ien)                      ien_q <= wdata_i & IEN_MASK;
    end
  end

  always_comb begin
    stat_w          = '0;
    stat_w[ST_BUSY] = busy;
    stat_w[ST_NEXT] = !busy;
    stat_w[ST_DONE] = wcf_q;
    stat_w[ST_ERR]  = wef_q;
    stat_w[ST_ALM]  = flags_b[2];
    stat_w[ST_NV]   = flags_b[1];
    stat_w[ST_SV]   = flags_b[0];
  end

  always_comb begin
    unique case (addr_i)
      OFS_CSEC:  rd_w = 32'(cnt_sec);
      OFS_CFRAC: rd_w = 32'(cnt_frac);
      OFS_ASEC:  rd_w = 32'(alm_sec);
      OFS_AFRAC: rd_w = 32'(alm_frac);
      OFS_CTRL:  rd_w = 32'(run_en) << CTRL_EN;
      OFS_STAT:  rd_w = stat_w;
      OFS_IEN:   rd_w = ien_q;
      default:   rd_w = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_w;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(ien_q & stat_w);

  AST_WCF_RDCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == OFS_STAT) && !done) |=> !wcf_q);  // R3
  AST_REJECT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lp && busy) |=> wef_q);  // R5
  AST_IEN_NOBUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_ien && !busy) |=> !busy);  // R4
  AST_DONE_SETS_WCF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> wcf_q);  // R2
endmodule

// File: tb/lp_rtc_tb_top.sv
module lp_rtc_tb_top;
  import lp_rtc_pkg::*;

  logic        clk = 1'b0, lp_clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0, errors = 0;

  localparam int LP_HALF = 31;
  localparam logic [31:0] SECS = 32'h1234_5678;

  always #5 clk = ~clk;
  always #(LP_HALF) lp_clk = ~lp_clk;

  lp_rtc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lp_clk_i(lp_clk),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_idle(output logic [31:0] s);
    s = 32'h400;
    for (int i = 0; i < 500 && s[ST_BUSY]; i++) bus_rd(OFS_STAT, s);
  endtask

  task automatic wr_sync(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] s;
    bus_wr(a, d);
    wait_idle(s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s, v, sec, frac;
    longint t1, t2, n, start, stop;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(OFS_STAT, s);  chk("R1 status", s, 32'h203);
    bus_rd(OFS_CSEC, v);  chk("R1 seconds", v, 32'h0);
    bus_rd(OFS_ASEC, v);  chk("R1 alarm seconds", v, 32'hFFFF_FFFF);
    bus_rd(OFS_CTRL, v);  chk("R1 control", v, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R4 interrupt enable at bus speed, masked
    bus_wr(OFS_IEN, 32'hFFFF_FFFF);
    bus_rd(OFS_STAT, s);  chk("R4 no busy/complete", s & 32'h500, 32'h0);
    bus_rd(OFS_IEN, v);   chk("R4 ien readback", v, 32'h390);
    bus_wr(OFS_IEN, 32'h0);

    // R2 busy then complete; R3 read clears complete
    bus_wr(OFS_CTRL, 32'h8);
    bus_rd(OFS_STAT, s);  chk("R2 busy set, next clear", s & 32'h600, 32'h400);
    wait_idle(s);         chk("R2 complete on idle", s & 32'h700, 32'h300);
    bus_rd(OFS_STAT, s);  chk("R3 complete cleared by read", s & 32'h100, 32'h0);
    bus_rd(OFS_CTRL, v);  chk("R10 control readback", v, 32'h8);

    // R7 frozen while non-valid
    repeat (20) @(posedge lp_clk);
    bus_rd(OFS_CFRAC, v); chk("R7 frozen while non-valid", v, 32'h0);
    wr_sync(OFS_STAT, 32'h3);
    bus_rd(OFS_STAT, s);  chk("R6 clear non-valid/violation", s & 32'h3, 32'h0);
    repeat (20) @(posedge lp_clk);
    bus_rd(OFS_CFRAC, v); chk("R7 frozen before seconds write", v, 32'h0);

    // R7 run with carry, timed window
    wr_sync(OFS_CFRAC, 32'h7FF0);
    repeat (10) @(posedge lp_clk);
    bus_rd(OFS_CFRAC, v); chk("R7 fraction held before seconds", v, 32'h7FF0);
    bus_wr(OFS_CSEC, SECS);
    t1 = longint'($time);
    wait_idle(s);
    repeat (40) @(posedge lp_clk);
    bus_rd(OFS_STAT, s);  chk("R8 unset alarm stays quiet", s & 32'h10, 32'h0);
    bus_wr(OFS_CTRL, 32'h0);
    t2 = longint'($time);
    wait_idle(s);
    bus_rd(OFS_CSEC, sec);
    bus_rd(OFS_CFRAC, frac);
    chk("R7 seconds carry", sec, SECS + 32'd1);
    start = (longint'(SECS) << 15) | 64'h7FF0;
    stop  = (longint'(sec) << 15) | longint'(frac);
    n = (t2 - t1) / (2 * LP_HALF);
    checks++;
    if (stop - start < n - 3 || stop - start > n + 3) begin
      errors++;
      $display("FAIL R7 elapsed actual=%0d expected=%0d+-3", stop - start, n);
    end
    repeat (10) @(posedge lp_clk);
    bus_rd(OFS_CFRAC, v); chk("R7 stopped counter stable", v, frac);

    // R8 alarm, R9 irq, R6 clear
    wr_sync(OFS_ASEC, SECS + 32'd1);
    wr_sync(OFS_AFRAC, 32'h100);
    bus_wr(OFS_IEN, 32'h10);
    chk("R9 irq low before alarm", 32'(irq), 32'h0);
    wr_sync(OFS_CTRL, 32'h8);
    repeat (300) @(posedge lp_clk);
    bus_rd(OFS_STAT, s);  chk("R8 alarm flag", s & 32'h10, 32'h10);
    chk("R9 irq on alarm", 32'(irq), 32'h1);
    wr_sync(OFS_STAT, 32'h0);
    bus_rd(OFS_STAT, s);  chk("R6 zero write keeps alarm", s & 32'h10, 32'h10);
    wr_sync(OFS_STAT, 32'h10);
    repeat (4) @(negedge clk);
    bus_rd(OFS_STAT, s);  chk("R6 alarm cleared", s & 32'h10, 32'h0);
    chk("R9 irq drops after clear", 32'(irq), 32'h0);

    // R9 write-complete irq, R3 read clears it
    bus_wr(OFS_IEN, 32'h100);
    bus_wr(OFS_AFRAC, 32'h5);
    repeat (80) @(negedge clk);
    chk("R9 irq on complete", 32'(irq), 32'h1);
    bus_rd(OFS_STAT, s);  chk("R3 read shows complete", s & 32'h100, 32'h100);
    chk("R3 irq drops after status read", 32'(irq), 32'h0);

    // R5 reject while busy
    bus_wr(OFS_IEN, 32'h80);
    bus_wr(OFS_ASEC, 32'hAAAA_0000);
    bus_wr(OFS_ASEC, 32'h5555_FFFF);
    wait_idle(s);         chk("R5 write error", s & 32'h80, 32'h80);
    bus_rd(OFS_ASEC, v);  chk("R5 target unchanged", v, 32'hAAAA_0000);
    chk("R9 irq on error", 32'(irq), 32'h1);
    wr_sync(OFS_STAT, 32'h80);
    bus_rd(OFS_STAT, s);  chk("R6 error cleared", s & 32'h80, 32'h0);
    chk("R9 irq low after error clear", 32'(irq), 32'h0);
    bus_wr(OFS_IEN, 32'h0);

    // R10 sweeps over alarm fields
    wr_sync(OFS_CTRL, 32'h0);
    for (int b = 0; b < 32; b++) begin
      wr_sync(OFS_ASEC, 32'h1 << b);
      bus_rd(OFS_ASEC, v); chk("R10 alarm seconds walk", v, 32'h1 << b);
    end
    for (int k = 0; k < 16; k++) begin
      wr_sync(OFS_AFRAC, 32'hFFFF_0000 | (32'(k) * 32'h0911));
      bus_rd(OFS_AFRAC, v); chk("R10 alarm fraction 15 bits", v, (32'(k) * 32'h0911) & 32'h7FFF);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule